// File: doc/BRIEF.md
# MII Transmit Nibble Serializer with Flow Control

This block sits between a byte-wide packet source and the transmit half of a Media Independent Interface. The source presents frame bytes over a valid/ready handshake with an end-of-frame marker. The block puts a preamble and start-of-frame delimiter in front of each frame, splits every byte into two 4-bit nibbles, drives them on the 4-bit transmit data bus with a transmit-enable strobe, and then enforces an interframe gap. The whole block runs on the transmit clock supplied by the PHY. Nothing in it depends on the clock's frequency, so the same logic serves the 2.5 MHz and 25 MHz rates.

The block has two modes, chosen by a mode input. In full-duplex mode the PHY collision input serves as a pause request. While the request is asserted no new frame starts, but a frame that is already on the wire runs to its end. In half-duplex mode a collision never blocks transmission. The block only records it in a sticky flag, which software clears, and it reports the synchronized carrier-sense level. Both PHY status inputs are asynchronous and pass through a multi-stage synchronizer before they are used.

Top module: `mii_tx_serializer`

## Requirements
- R1: While reset is held, txen is 0, txd is 0, s_ready is 0 and col_flag is 0.
- R2: Each frame opens with PRE_NIBBLES (default 15) consecutive nibbles of value 4'h5, followed by one nibble of 4'hD. txen is 1 for all of them.
- R3: Every accepted byte is sent as two consecutive nibbles with txen high. Bits [3:0] go first and bits [7:4] second, and txd[0] carries the lowest bit of each nibble.
- R4: txen drops in the cycle right after the high nibble of the byte marked s_last. A frame of N bytes therefore holds txen high for exactly PRE_NIBBLES + 1 + 2N cycles.
- R5: At least IFG_NIBBLES (default 24) cycles with txen low separate two frames. When the next frame is already waiting, the gap is exactly IFG_NIBBLES cycles.
- R6: s_ready is 1 only in the cycles in which the delimiter or a low nibble is on txd. It is 0 while preamble or high nibbles are sent, while idle, and during the gap.
- R7: In full-duplex mode (full_duplex = 1), a synchronized high level on col_async keeps txen low and prevents a new frame from starting. Once the level is removed, the pending frame starts.
- R8: In full-duplex mode, raising col_async in the middle of a frame does not shorten that frame.
- R9: crs_seen follows crs_async through SYNC_STAGES (default 2) flip-flops. A rising input becomes visible after exactly two clock edges.
- R10: In half-duplex mode (full_duplex = 0), a synchronized collision seen while txen is high sets col_flag, and col_flag stays set after the collision ends. A collision never blocks a frame start in this mode, and col_flag never sets in full-duplex mode.
- R11: A one-cycle pulse on col_clear returns col_flag to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1 = collision input acts as pause request; 0 = collision only reported |
| s_valid | input | 1 | Source byte valid |
| s_data | input | 8 | Source byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Block accepts the byte this cycle |
| col_async | input | 1 | PHY collision, asynchronous |
| crs_async | input | 1 | PHY carrier sense, asynchronous |
| col_clear | input | 1 | Clears the sticky collision flag |
| txd | output | 4 | Transmit nibble |
| txen | output | 1 | Transmit enable |
| col_flag | output | 1 | Sticky half-duplex collision flag |
| crs_seen | output | 1 | Synchronized carrier sense |

## Verification
The bench builds the block with its default parameters: a 15-nibble preamble, a 24-nibble gap and two synchronizer stages. It therefore compares the exact nibble streams, the frame lengths and the gap widths that a real link would see. Because frames are queued back to back, the gap is measured at its minimum, where an off-by-one in the gap counter would show. The synchronizer latency is counted edge by edge, and collision windows are placed before a frame, in the middle of a frame, and in both modes.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

    localparam logic [3:0] PRE_NIB = 4'h5;
    localparam logic [3:0] SFD_NIB = 4'hD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_LO,
        ST_HI,
        ST_GAP
    } tx_state_e;

    // Byte fetched while its predecessor's low nibble is on the wire
    typedef struct packed {
        logic       ok;
        logic       last;
        logic [7:0] data;
    } pend_byte_t;

    // Registered MII output pair
    typedef struct packed {
        logic       en;
        logic [3:0] nib;
    } mii_out_t;

    function automatic logic [3:0] lo_nib(input logic [7:0] b);
        return b[3:0];
    endfunction

    function automatic logic [3:0] hi_nib(input logic [7:0] b);
        return b[7:4];
    endfunction

endpackage

// File: rtl/mii_tx_sync.sv
module mii_tx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/mii_tx_fsm.sv
module mii_tx_fsm
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    output logic [3:0] txd,
    output logic       txen
);
    localparam int MAXN = (PRE_NIBBLES > IFG_NIBBLES) ? PRE_NIBBLES : IFG_NIBBLES;
    localparam int CW   = $clog2(MAXN + 1);
    localparam logic [CW-1:0] PRE_END = CW'(PRE_NIBBLES);
    localparam logic [CW-1:0] IFG_END = CW'(IFG_NIBBLES);

    tx_state_e  state;
    logic [CW-1:0] cnt;
    logic [3:0] cur_hi;
    logic       cur_last;
    pend_byte_t pend;
    mii_out_t   out_q;
    logic       start_ok;

    assign start_ok = s_valid && !hold;
    assign s_ready  = (state == ST_SFD) || (state == ST_LO && !cur_last);
    assign txd      = out_q.nib;
    assign txen     = out_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_hi   <= '0;
            cur_last <= 1'b0;
            pend     <= '0;
            out_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state <= ST_PRE;
                        cnt   <= CW'(1);
                        out_q <= '{en: 1'b1, nib: PRE_NIB};
                    end
                end
                ST_PRE: begin
                    if (cnt == PRE_END) begin
                        state     <= ST_SFD;
                        out_q.nib <= SFD_NIB;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_SFD: begin
                    if (s_valid) begin
                        out_q.nib <= lo_nib(s_data);
                        cur_hi    <= hi_nib(s_data);
                        cur_last  <= s_last;
                        state     <= ST_LO;
                    end else begin
                        out_q <= '0;
                        cnt   <= CW'(1);
                        state <= ST_GAP;
                    end
                end
                ST_LO: begin
                    out_q.nib <= cur_hi;
                    pend      <= '{ok: s_valid && !cur_last, last: s_last, data: s_data};
                    state     <= ST_HI;
                end
                ST_HI: begin
                    if (pend.ok) begin
                        out_q.nib <= lo_nib(pend.data);
                        cur_hi    <= hi_nib(pend.data);
                        cur_last  <= pend.last;
                        state     <= ST_LO;
                    end else begin
                        out_q <= '0;
                        cnt   <= CW'(1);
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cnt == IFG_END) begin
                        if (start_ok) begin
                            state <= ST_PRE;
                            cnt   <= CW'(1);
                            out_q <= '{en: 1'b1, nib: PRE_NIB};
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: every preamble cycle carries the 0x5 pattern with enable high
    a_r2_preamble_value: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE) |-> (txen && txd == PRE_NIB));

    // R3: high nibble follows the low nibble of the same byte
    a_r3_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LO) |=> (txen && txd == $past(cur_hi)));

    // R8: once started, preamble and low-nibble cycles never end the frame
    a_r8_no_cut: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE || state == ST_LO) |=> txen);

    // R5: the gap counter keeps the line quiet until it completes
    a_r5_gap_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && cnt != IFG_END) |=> !txen);

    // R6: no acceptance while the wire shows preamble or a high nibble
    a_r6_ready_windows: assert property (@(posedge clk) disable iff (rst)
        (txen && (state == ST_PRE || state == ST_HI)) |-> !s_ready);

endmodule

// File: rtl/mii_tx_status.sv
module mii_tx_status (
    input  logic clk,
    input  logic rst,
    input  logic full_duplex,
    input  logic col_s,
    input  logic txen,
    input  logic col_clear,
    output logic col_flag
);
    logic set_hit;

    assign set_hit = !full_duplex && col_s && txen;

    always_ff @(posedge clk) begin
        if (rst)            col_flag <= 1'b0;
        else if (set_hit)   col_flag <= 1'b1;
        else if (col_clear) col_flag <= 1'b0;
    end

    // R10: a half-duplex collision during transmission leaves the flag set
    a_r10_sticky_set: assert property (@(posedge clk) disable iff (rst)
        (!full_duplex && col_s && txen) |=> col_flag);

    // R11: a clear with no collision present drops the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (col_clear && !(col_s && txen)) |=> !col_flag);

endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       full_duplex,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    input  logic       col_async,
    input  logic       crs_async,
    input  logic       col_clear,
    output logic [3:0] txd,
    output logic       txen,
    output logic       col_flag,
    output logic       crs_seen
);
    logic [1:0] st_sync;
    logic       col_s;
    logic       hold;

    mii_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({crs_async, col_async}),
        .q_sync  (st_sync)
    );

    assign col_s    = st_sync[0];
    assign crs_seen = st_sync[1];
    assign hold     = full_duplex && col_s;

    mii_tx_fsm #(.PRE_NIBBLES(PRE_NIBBLES), .IFG_NIBBLES(IFG_NIBBLES)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .s_valid (s_valid),
        .s_data  (s_data),
        .s_last  (s_last),
        .s_ready (s_ready),
        .txd     (txd),
        .txen    (txen)
    );

    mii_tx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .full_duplex (full_duplex),
        .col_s       (col_s),
        .txen        (txen),
        .col_clear   (col_clear),
        .col_flag    (col_flag)
    );

    // R7: a full-duplex pause keeps an idle line idle
    a_r7_pause_blocks: assert property (@(posedge clk) disable iff (rst)
        (!txen && full_duplex && col_s) |=> !txen);

    // R10: no sticky flag can rise in full-duplex mode
    a_r10_fd_no_flag: assert property (@(posedge clk) disable iff (rst)
        (full_duplex && !col_flag && !col_clear) |=> (!col_flag || !$past(full_duplex)));

endmodule

// File: tb/mii_tx_serializer_bench.sv
module mii_tx_serializer_bench;

    localparam int PRE = 15;
    localparam int IFG = 24;

    localparam int PH_PRE = 0;
    localparam int PH_SFD = 1;
    localparam int PH_LO  = 2;
    localparam int PH_HI  = 3;

    typedef struct {
        logic [3:0] nib;
        int         ph;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       full_duplex = 1'b1;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       col_async = 1'b0;
    logic       crs_async = 1'b0;
    logic       col_clear = 1'b0;
    logic [3:0] txd;
    logic       txen;
    logic       col_flag;
    logic       crs_seen;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 0;

    exp_item_t exp_q[$];
    int        len_q[$];
    int        frames_done = 0;
    int        last_gap = 0;
    int        last_run = 0;

    always #4 clk = ~clk;

    mii_tx_serializer u_mii_tx_serializer (
        .clk         (clk),
        .rst         (rst),
        .full_duplex (full_duplex),
        .s_valid     (s_valid),
        .s_data      (s_data),
        .s_last      (s_last),
        .s_ready     (s_ready),
        .col_async   (col_async),
        .crs_async   (crs_async),
        .col_clear   (col_clear),
        .txd         (txd),
        .txen        (txen),
        .col_flag    (col_flag),
        .crs_seen    (crs_seen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: queues the expected wire image, then hands bytes over
    task automatic send_frame(input int n, input logic [7:0] seed);
        logic [7:0] b;
        exp_item_t  it;
        @(negedge clk);
        for (int k = 0; k < PRE; k++) begin
            it.nib = 4'h5; it.ph = PH_PRE; exp_q.push_back(it);
        end
        it.nib = 4'hD; it.ph = PH_SFD; exp_q.push_back(it);
        for (int i = 0; i < n; i++) begin
            b = seed + 8'(i * 37);
            it.nib = b[3:0]; it.ph = PH_LO; exp_q.push_back(it);
            it.nib = b[7:4]; it.ph = PH_HI; exp_q.push_back(it);
        end
        len_q.push_back(PRE + 1 + 2 * n);
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1;
            s_data  = seed + 8'(i * 37);
            s_last  = (i == n - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    // Monitor: pops the scoreboard as nibbles appear
    bit prev_txen = 0;
    bit seen_frame = 0;
    int idle_cnt = 0;
    int run_len = 0;

    always @(negedge clk) begin
        exp_item_t e;
        int el;
        if (rst) begin
            prev_txen = 0;
            idle_cnt  = 0;
        end else begin
            if (txen) begin
                if (!prev_txen) begin
                    if (seen_frame) begin
                        last_gap = idle_cnt;
                        chk(idle_cnt >= IFG, "R5 gap", idle_cnt, IFG);
                    end
                    run_len = 0;
                end
                run_len++;
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected nibble", txd, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(txd == e.nib, (e.ph <= PH_SFD) ? "R2 preamble/sfd" : "R3 byte nibble",
                        txd, e.nib);
                    if (e.ph == PH_PRE || e.ph == PH_HI)
                        chk(s_ready == 1'b0, "R6 ready low", s_ready, 0);
                    if (e.ph == PH_SFD)
                        chk(s_ready == 1'b1, "R6 ready at sfd", s_ready, 1);
                end
            end else begin
                if (prev_txen) begin
                    el = (len_q.size() != 0) ? len_q.pop_front() : -1;
                    chk(run_len == el, "R4 frame length", run_len, el);
                    last_run   = run_len;
                    seen_frame = 1;
                    frames_done++;
                    idle_cnt = 0;
                end
                idle_cnt++;
                chk(s_ready == 1'b0 || s_valid, "R6 ready idle", s_ready, 0);
            end
            prev_txen = txen;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        bit saw;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(txen == 1'b0, "R1 txen", txen, 0);
        chk(txd == 4'h0, "R1 txd", txd, 0);
        chk(s_ready == 1'b0, "R1 ready", s_ready, 0);
        chk(col_flag == 1'b0, "R1 col_flag", col_flag, 0);
        rst = 1'b0;

        // R3: single-byte frame, full duplex, no pause
        send_frame(1, 8'hA7);
        wait (frames_done == 1);

        // R5: two frames back to back give the minimum gap
        send_frame(5, 8'h3C);
        send_frame(3, 8'h91);
        wait (frames_done == 3);
        chk(last_gap == IFG, "R5 exact gap", last_gap, IFG);

        // R7: pause held before the frame blocks its start
        @(negedge clk);
        col_async = 1'b1;
        repeat (3) @(negedge clk);
        fork
            send_frame(4, 8'h5E);
            begin
                saw = 0;
                repeat (40) begin
                    @(negedge clk);
                    if (txen) saw = 1;
                end
                chk(!saw, "R7 held off", saw, 0);
                col_async = 1'b0;
            end
        join
        wait (frames_done == 4);

        // R8: pause raised mid-frame does not cut it
        fork
            send_frame(20, 8'h12);
            begin
                wait (txen);
                repeat (10) @(negedge clk);
                col_async = 1'b1;
            end
        join
        wait (frames_done == 5);
        chk(last_run == PRE + 1 + 40, "R8 full length", last_run, PRE + 1 + 40);
        chk(col_flag == 1'b0, "R10 no flag in full duplex", col_flag, 0);
        @(negedge clk);
        col_async = 1'b0;

        // R9: carrier sense synchronizer latency
        crs_async = 1'b1;
        @(negedge clk);
        chk(crs_seen == 1'b0, "R9 after one edge", crs_seen, 0);
        @(negedge clk);
        chk(crs_seen == 1'b1, "R9 after two edges", crs_seen, 1);
        crs_async = 1'b0;
        repeat (3) @(negedge clk);
        chk(crs_seen == 1'b0, "R9 falls", crs_seen, 0);

        // R10: half duplex, collision does not block and sets the flag
        full_duplex = 1'b0;
        col_async   = 1'b1;
        repeat (3) @(negedge clk);
        send_frame(2, 8'hC4);
        wait (frames_done == 6);
        chk(col_flag == 1'b1, "R10 flag set", col_flag, 1);
        col_async = 1'b0;
        repeat (4) @(negedge clk);
        chk(col_flag == 1'b1, "R10 sticky", col_flag, 1);

        // R11: clear pulse
        col_clear = 1'b1;
        @(negedge clk);
        col_clear = 1'b0;
        chk(col_flag == 1'b0, "R11 cleared", col_flag, 0);
        repeat (4) @(negedge clk);
        chk(col_flag == 1'b0, "R11 stays clear", col_flag, 0);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        finish_up();
    end

endmodule